// File: doc/BRIEF.md
# Memory access reorder queue

The block sits between one processor's in-order memory access stream and a single-ported memory. It accepts loads, stores and typed fences in program order into an eight-slot queue. Each cycle it presents at most one access to the memory: the oldest queued access that the relaxed-ordering rules allow to go ahead of every older access that has not yet completed. Entries leave the queue in program order once they are complete.

Reordering is decided pairwise. Two loads may always swap. A pair that includes a store may swap only when the two addresses differ. A fence blocks one class of younger access while a chosen class of older access is still outstanding, and leaves every other combination free. Load results go back to the requester tagged with the sequence number the queue gave the load when it was accepted.

Memory handshake: an access is taken when `mem_req_o` and `mem_gnt_i` are both high at a clock edge. The memory answers later, in any order, by pulsing `mem_rsp_valid_i` with the slot tag it was given. An access counts as outstanding from acceptance until that answer arrives. `DEPTH` must be a power of two and at least 2.

Top module: `mem_reorder_q`

## Requirements
- R1: A younger load may be sent to memory while an older load is still outstanding, whether or not the two addresses are equal.
- R2: A younger store is held while an older load to the same address is outstanding, and a younger load is held while an older store to the same address is outstanding. With different addresses both may go ahead.
- R3: A younger store is held while an older store to the same address is outstanding. With different addresses it may go ahead.
- R4: `in_op_i` encodes 0 as load, 1 as store and 2 or 3 as fence. A fence's `in_fkind_i` bit 1 selects the guarded older class and bit 0 the blocked younger class (0 load, 1 store), giving load-load=0, load-store=1, store-load=2 and store-store=3. Any access younger than the fence in the blocked class is not sent while an access older than the fence in the guarded class is outstanding.
- R5: A fence places no hold on a younger access outside its blocked class, nor on any access when no older access of its guarded class is outstanding.
- R6: Among the entries allowed to go, the oldest is presented first. At most one access is presented per cycle, and only an entry not yet sent is presented.
- R7: The queue holds 8 entries. `in_ready_o` is low exactly when all 8 are occupied.
- R8: Entries retire in program order. A completed access leaves when it is the oldest entry. A fence leaves once no older entry remains, so every older access has completed. Freed slots become available for new requests.
- R9: One cycle after a memory answer for a load, `ld_valid_o` pulses with that load's sequence number and the returned data. An answer for a store produces no pulse.
- R10: After reset the queue is empty, `in_ready_o` is high, and `mem_req_o` and `ld_valid_o` are low.
- R11: `in_seq_o` shows the sequence number the offered request would receive. It starts at 0 after reset and advances by one for every accepted request, fences included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request offered |
| in_ready_o | output | 1 | Queue can accept a request |
| in_op_i | input | 2 | 0 load, 1 store, 2/3 fence |
| in_fkind_i | input | 2 | Fence kind: bit 1 guarded older class, bit 0 blocked younger class |
| in_addr_i | input | ADDR_W | Access address |
| in_wdata_i | input | DATA_W | Store data |
| in_seq_o | output | SEQ_W | Sequence number for the offered request |
| mem_req_o | output | 1 | Access presented to memory |
| mem_gnt_i | input | 1 | Memory takes the presented access |
| mem_we_o | output | 1 | Presented access is a store |
| mem_addr_o | output | ADDR_W | Presented address |
| mem_wdata_o | output | DATA_W | Presented store data |
| mem_tag_o | output | IDX_W | Slot tag of the presented access |
| mem_rsp_valid_i | input | 1 | Memory completes an access |
| mem_rsp_tag_i | input | IDX_W | Slot tag of the completed access |
| mem_rsp_data_i | input | DATA_W | Load data |
| ld_valid_o | output | 1 | Load result valid |
| ld_seq_o | output | SEQ_W | Sequence number of the returned load |
| ld_data_o | output | DATA_W | Returned load data |

## Verification
The bench builds the queue with its defaults: 8 slots, 16-bit addresses, 32-bit data and 8-bit sequence numbers. Eight slots let one run fill the queue completely and show a fence retiring ahead of a full refill. Because the bench memory holds every answer until told to give it, an older access stays outstanding for as long as needed. That makes each ordering pair, and each fence kind against matching and non-matching younger accesses, directly observable in whether the younger access is presented.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;

  typedef enum logic [1:0] {
    SLOT_WAIT   = 2'd0,
    SLOT_ISSUED = 2'd1,
    SLOT_DONE   = 2'd2
  } slot_state_e;
endpackage

// File: rtl/mrq_elig.sv
// Pairwise hazard check: an entry is held if any older entry orders it.
module mrq_elig #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0]             is_ld_i,
  input  logic [DEPTH-1:0]             is_st_i,
  input  logic [DEPTH-1:0]             is_fn_i,
  input  logic [DEPTH-1:0]             outst_i,
  input  logic [DEPTH-1:0][1:0]        fkind_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [DEPTH-1:0][IDX_W-1:0]  age_i,
  output logic [DEPTH-1:0]             elig_o
);
  logic [DEPTH-1:0] pend_ld_older;
  logic [DEPTH-1:0] pend_st_older;
  logic [DEPTH-1:0] blk;

  // outstanding accesses older than each slot, split by class
  always_comb begin
    pend_ld_older = '0;
    pend_st_older = '0;
    for (int j = 0; j < DEPTH; j++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (vld_i[k] && outst_i[k] && (age_i[k] < age_i[j])) begin
          if (is_ld_i[k]) pend_ld_older[j] = 1'b1;
          if (is_st_i[k]) pend_st_older[j] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    blk = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (vld_i[j] && (age_i[j] < age_i[i])) begin
          // same-address pair with a store on either side
          if (outst_i[j] && (is_st_i[j] || is_st_i[i]) && (addr_i[j] == addr_i[i]))
            blk[i] = 1'b1;
          // typed fence
          if (is_fn_i[j]) begin
            if ((fkind_i[j][1] ? pend_st_older[j] : pend_ld_older[j]) &&
                (fkind_i[j][0] ? is_st_i[i] : is_ld_i[i]))
              blk[i] = 1'b1;
          end
        end
      end
    end
  end

  assign elig_o = ~blk;
endmodule

// File: rtl/mrq_pick.sv
// Oldest-first selection starting at the head slot.
module mrq_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] pos;

  always_comb begin
    found_o = 1'b0;
    idx_o   = head_i;
    pos     = head_i;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = head_i + IDX_W'(k);
      if (req_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end
endmodule

// File: rtl/mrq_ldret.sv
// Registered load-return stage.
module mrq_ldret #(
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      seq_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        seq_o  <= seq_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/mem_reorder_q.sv
module mem_reorder_q #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_op_i,
  input  logic [1:0]        in_fkind_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_wdata_i,
  output logic [SEQ_W-1:0]  in_seq_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [IDX_W-1:0]  mem_tag_o,
  input  logic              mem_rsp_valid_i,
  input  logic [IDX_W-1:0]  mem_rsp_tag_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              ld_valid_o,
  output logic [SEQ_W-1:0]  ld_seq_o,
  output logic [DATA_W-1:0] ld_data_o
);
  import mrq_pkg::*;

  logic [IDX_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [SEQ_W-1:0]  seq_q;
  logic [DEPTH-1:0]  vld_q;
  slot_state_e       st_q    [DEPTH];
  logic [1:0]        op_q    [DEPTH];
  logic [1:0]        fk_q    [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DATA_W-1:0] wdata_q [DEPTH];
  logic [SEQ_W-1:0]  eseq_q  [DEPTH];

  logic [DEPTH-1:0]             is_ld, is_st, is_fn, outst, waiting, elig, cand;
  logic [DEPTH-1:0][1:0]        fk_p;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_p;
  logic [DEPTH-1:0][IDX_W-1:0]  age;

  logic             push, pop, issue, rsp_hit, ld_fire, sel_found;
  logic [IDX_W-1:0] sel_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign is_ld[g]   = vld_q[g] && (op_q[g] == OP_LOAD);
    assign is_st[g]   = vld_q[g] && (op_q[g] == OP_STORE);
    assign is_fn[g]   = vld_q[g] && op_q[g][1];
    assign outst[g]   = vld_q[g] && (st_q[g] != SLOT_DONE);
    assign waiting[g] = vld_q[g] && (st_q[g] == SLOT_WAIT);
    assign fk_p[g]    = fk_q[g];
    assign addr_p[g]  = addr_q[g];
    assign age[g]     = IDX_W'(g) - head_q;
  end

  mrq_elig #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_elig (
    .vld_i  (vld_q),
    .is_ld_i(is_ld),
    .is_st_i(is_st),
    .is_fn_i(is_fn),
    .outst_i(outst),
    .fkind_i(fk_p),
    .addr_i (addr_p),
    .age_i  (age),
    .elig_o (elig)
  );

  assign cand = waiting & elig;

  mrq_pick #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_pick (
    .req_i  (cand),
    .head_i (head_q),
    .found_o(sel_found),
    .idx_o  (sel_idx)
  );

  assign in_ready_o  = (count_q != CNT_W'(DEPTH));
  assign in_seq_o    = seq_q;
  assign push        = in_valid_i && in_ready_o;
  assign pop         = vld_q[head_q] && (st_q[head_q] == SLOT_DONE);

  assign mem_req_o   = sel_found;
  assign mem_we_o    = is_st[sel_idx];
  assign mem_addr_o  = addr_q[sel_idx];
  assign mem_wdata_o = wdata_q[sel_idx];
  assign mem_tag_o   = sel_idx;
  assign issue       = sel_found && mem_gnt_i;

  assign rsp_hit = mem_rsp_valid_i && vld_q[mem_rsp_tag_i] &&
                   (st_q[mem_rsp_tag_i] == SLOT_ISSUED);
  assign ld_fire = rsp_hit && is_ld[mem_rsp_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      seq_q   <= '0;
      vld_q   <= '0;
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_DONE;
    end else begin
      if (push) begin
        vld_q[tail_q] <= 1'b1;
        st_q[tail_q]  <= in_op_i[1] ? SLOT_DONE : SLOT_WAIT;
        tail_q        <= tail_q + 1'b1;
        seq_q         <= seq_q + 1'b1;
      end
      if (issue)   st_q[sel_idx]       <= SLOT_ISSUED;
      if (rsp_hit) st_q[mem_rsp_tag_i] <= SLOT_DONE;
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // payload needs no reset: qualified by vld_q
  always_ff @(posedge clk_i) begin
    if (push) begin
      op_q[tail_q]    <= in_op_i;
      fk_q[tail_q]    <= in_fkind_i;
      addr_q[tail_q]  <= in_addr_i;
      wdata_q[tail_q] <= in_wdata_i;
      eseq_q[tail_q]  <= seq_q;
    end
  end

  mrq_ldret #(
    .SEQ_W (SEQ_W),
    .DATA_W(DATA_W)
  ) u_ldret (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (ld_fire),
    .seq_i  (eseq_q[mem_rsp_tag_i]),
    .data_i (mem_rsp_data_i),
    .valid_o(ld_valid_o),
    .seq_o  (ld_seq_o),
    .data_o (ld_data_o)
  );
endmodule

// File: rtl/mrq_checker.sv
module mrq_checker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_i,
  input logic [SEQ_W-1:0] in_seq_i,
  input logic             mem_req_i,
  input logic [IDX_W-1:0] mem_tag_i,
  input logic             mem_rsp_valid_i,
  input logic             ld_valid_i,
  input logic [CNT_W-1:0] count_i,
  input logic [DEPTH-1:0] wait_i
);
  AST_REQ_FROM_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> wait_i[mem_tag_i]); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH)); // R7
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_i) |=> (in_seq_i == $past(in_seq_i) + 1'b1)); // R11
  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_i) |=> $stable(in_seq_i)); // R11
  AST_LD_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |-> $past(mem_rsp_valid_i)); // R9
endmodule

bind mem_reorder_q mrq_checker #(
  .DEPTH(DEPTH),
  .SEQ_W(SEQ_W),
  .IDX_W(IDX_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_ready_i     (in_ready_o),
  .in_seq_i       (in_seq_o),
  .mem_req_i      (mem_req_o),
  .mem_tag_i      (mem_tag_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .ld_valid_i     (ld_valid_o),
  .count_i        (count_q),
  .wait_i         (waiting)
);

// File: tb/mem_reorder_q_bench.sv
module mem_reorder_q_bench;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SEQ_W  = 8;
  localparam int IDX_W  = 3;
  localparam logic [ADDR_W-1:0] BASE = 16'h0100;

  // {op0[1:0], a0[3:0], fence_en, fkind[1:0], op1[1:0], a1[3:0], may_pass}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 4'd1, 1'b0, 2'd0, 2'd0, 4'd1, 1'b1},
    {2'd0, 4'd1, 1'b0, 2'd0, 2'd0, 4'd2, 1'b1},
    {2'd0, 4'd1, 1'b0, 2'd0, 2'd1, 4'd1, 1'b0},
    {2'd0, 4'd1, 1'b0, 2'd0, 2'd1, 4'd2, 1'b1},
    {2'd1, 4'd1, 1'b0, 2'd0, 2'd0, 4'd1, 1'b0},
    {2'd1, 4'd1, 1'b0, 2'd0, 2'd0, 4'd2, 1'b1},
    {2'd1, 4'd1, 1'b0, 2'd0, 2'd1, 4'd1, 1'b0},
    {2'd1, 4'd1, 1'b0, 2'd0, 2'd1, 4'd2, 1'b1},
    {2'd0, 4'd1, 1'b1, 2'd0, 2'd0, 4'd2, 1'b0},
    {2'd0, 4'd1, 1'b1, 2'd1, 2'd1, 4'd2, 1'b0},
    {2'd1, 4'd1, 1'b1, 2'd2, 2'd0, 4'd2, 1'b0},
    {2'd1, 4'd1, 1'b1, 2'd3, 2'd1, 4'd2, 1'b0},
    {2'd0, 4'd1, 1'b1, 2'd0, 2'd1, 4'd2, 1'b1},
    {2'd1, 4'd1, 1'b1, 2'd0, 2'd0, 4'd2, 1'b1},
    {2'd0, 4'd1, 1'b1, 2'd3, 2'd0, 4'd2, 1'b1},
    {2'd1, 4'd1, 1'b1, 2'd1, 2'd1, 4'd2, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_op = '0;
  logic [1:0]        in_fkind = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_wdata = '0;
  logic [SEQ_W-1:0]  in_seq;
  logic              mem_req, mem_we;
  logic              mem_gnt = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [IDX_W-1:0]  mem_tag;
  logic              rsp_valid = 1'b0;
  logic [IDX_W-1:0]  rsp_tag = '0;
  logic [DATA_W-1:0] rsp_data = '0;
  logic              ld_valid;
  logic [SEQ_W-1:0]  ld_seq;
  logic [DATA_W-1:0] ld_data;

  int checks = 0;
  int failures = 0;
  int n_log = 0;
  logic [IDX_W-1:0]  log_tag  [32];
  logic [ADDR_W-1:0] log_addr [32];

  always #4 clk = ~clk;

  mem_reorder_q u_mem_reorder_q (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op),
    .in_fkind_i(in_fkind), .in_addr_i(in_addr), .in_wdata_i(in_wdata),
    .in_seq_o(in_seq),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_tag_o(mem_tag),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_tag_i(rsp_tag), .mem_rsp_data_i(rsp_data),
    .ld_valid_o(ld_valid), .ld_seq_o(ld_seq), .ld_data_o(ld_data)
  );

  // issue monitor: sampled between the stimulus edge and the next rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_req && mem_gnt && n_log < 32) begin
      log_tag[n_log]  = mem_tag;
      log_addr[n_log] = mem_addr;
      n_log++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; mem_gnt = 1'b0; rsp_valid = 1'b0;
    wait_cyc(2);
    n_log = 0;
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [1:0] op, input logic [1:0] fk,
                      input logic [ADDR_W-1:0] a, output logic [SEQ_W-1:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_fkind = fk; in_addr = a;
    in_wdata = {16'hBEEF, a};
    s = in_seq;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic respond(input logic [IDX_W-1:0] t, input logic [DATA_W-1:0] d,
                         output logic v, output logic [SEQ_W-1:0] s,
                         output logic [DATA_W-1:0] q);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = t; rsp_data = d;
    @(negedge clk);
    v = ld_valid; s = ld_seq; q = ld_data;
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [SEQ_W-1:0]  s;
    logic [SEQ_W-1:0]  seqs [8];
    logic              v;
    logic [SEQ_W-1:0]  rs;
    logic [DATA_W-1:0] rq;
    do_reset();

    // R10 / R11: reset state
    @(negedge clk);
    check(in_ready == 1'b1, "R10 ready after reset", 32'(in_ready), 1);
    check(mem_req == 1'b0, "R10 no request after reset", 32'(mem_req), 0);
    check(ld_valid == 1'b0, "R10 no load result after reset", 32'(ld_valid), 0);
    check(in_seq == '0, "R11 sequence starts at zero", 32'(in_seq), 0);

    // ordering table: R1..R5
    for (int vi = 0; vi < NV; vi++) begin
      logic [1:0] op0, op1, fk;
      logic [3:0] a0, a1;
      logic fen, pass;
      string rq_tag;
      {op0, a0, fen, fk, op1, a1, pass} = VEC[vi];
      if (fen) rq_tag = pass ? "R5" : "R4";
      else if (op0 == 2'd0 && op1 == 2'd0) rq_tag = "R1";
      else if (op0 == 2'd1 && op1 == 2'd1) rq_tag = "R3";
      else rq_tag = "R2";
      do_reset();
      mem_gnt = 1'b1;
      push(op0, 2'd0, BASE + ADDR_W'(a0), s);
      if (fen) push(2'd2, fk, BASE + 16'h40, s);
      push(op1, 2'd0, BASE + ADDR_W'(a1), s);
      wait_cyc(3);
      check(n_log == 1 + int'(pass), rq_tag, 32'(n_log), 32'(1 + int'(pass)));
      respond(log_tag[0], 32'hA000_0000 + 32'(vi), v, rs, rq);
      check(v == (op0 == 2'd0), "R9 load result only for loads", 32'(v),
            32'(op0 == 2'd0));
      wait_cyc(3);
      check(n_log == 2 && log_addr[1] == BASE + ADDR_W'(a1), rq_tag,
            32'(log_addr[1]), 32'(BASE + ADDR_W'(a1)));
    end

    // R6: oldest first, one per cycle
    do_reset();
    for (int i = 0; i < 3; i++) push(2'd0, 2'd0, BASE + ADDR_W'(5 + i), seqs[i]);
    check(in_seq == 8'd3, "R11 sequence advanced by three", 32'(in_seq), 3);
    mem_gnt = 1'b1;
    wait_cyc(5);
    check(n_log == 3, "R6 one issue per waiting load", 32'(n_log), 3);
    for (int i = 0; i < 3; i++)
      check(log_addr[i] == BASE + ADDR_W'(5 + i), "R6 oldest first",
            32'(log_addr[i]), 32'(BASE + ADDR_W'(5 + i)));
    // R9: results carry sequence numbers, answered out of order
    for (int i = 2; i >= 0; i--) begin
      respond(log_tag[i], 32'hC0DE_0000 + 32'(i), v, rs, rq);
      check(v && rs == seqs[i] && rq == 32'hC0DE_0000 + 32'(i),
            "R9 load result tag", 32'(rs), 32'(seqs[i]));
    end

    // R7 / R8: capacity and retirement
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1)
        check(in_ready == 1'b1, "R7 ready with one slot free", 32'(in_ready), 1);
      push(2'd0, 2'd0, BASE + ADDR_W'(i), s);
    end
    check(in_ready == 1'b0, "R7 not ready when full", 32'(in_ready), 0);
    mem_gnt = 1'b1;
    wait_cyc(DEPTH + 2);
    for (int i = 0; i < DEPTH; i++) respond(log_tag[i], 32'(i), v, rs, rq);
    wait_cyc(DEPTH + 2);
    check(in_ready == 1'b1, "R8 slots freed after completion", 32'(in_ready), 1);

    // R8: fence with nothing older leaves at once
    do_reset();
    push(2'd2, 2'd3, BASE, s);
    wait_cyc(2);
    for (int i = 0; i < DEPTH - 1; i++) push(2'd0, 2'd0, BASE + ADDR_W'(i), s);
    check(in_ready == 1'b1, "R8 fence retired", 32'(in_ready), 1);
    push(2'd0, 2'd0, BASE + 16'h30, s);
    check(in_ready == 1'b0, "R7 full after refill", 32'(in_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule